// File: doc/BRIEF.md
# Four-Quadrant Rectangular-to-Polar Converter

This block converts a vector given in rectangular form into a magnitude and an angle in degrees over the whole circle. The work is done by an iterative CORDIC vectoring core. On its own, that core is only correct for vectors whose x component is not negative. The core stays unchanged. Around it, a thin conditioning layer does three things. It mirrors left-half-plane vectors through the origin before they reach the core. It remembers which quadrant the operand came from. It adds or subtracts a half turn to the core's angle in one extra output register.

A caller presents both operands and raises `start` together with `enable` for one clock. It keeps `enable` high for 34 enabled clock edges in total, counting the start edge, and then reads the two results. Lowering `enable` freezes the whole computation, and raising it again resumes from where it stopped. Inputs and magnitude are signed fixed point with 16 fractional bits. The angle carries 9 integer bits and 24 fractional bits, so that both +180 and -180 degrees fit.

Top module: `quad_polar_conv`

## Requirements
- R1: A synchronous, active-high reset clears both outputs to zero.
- R2: For operands with |x| and |y| below 16384, `modOut` equals sqrt(x*x + y*y) within 0.005, as an unsigned-valued 16Q16 word that never has its top bit set.
- R3: For x > 0, `angleOut` equals atan2(y, x) in degrees (value = word / 2^24) within 0.01 degree and lies in (-90, +90).
- R4: For x < 0 and y > 0, the angle lies in (+90, +180) and equals atan2(y, x) within 0.01 degree.
- R5: For x < 0 and y < 0, the angle lies in (-180, -90) and equals atan2(y, x) within 0.01 degree.
- R6: A vector on the negative real axis (x < 0, y = 0) reports +180 degrees, never -180.
- R7: For x = 0, the angle is +90 degrees when y > 0 and -90 degrees when y < 0.
- R8: Results are final after the 34th enabled rising edge counted from the start edge. Both outputs change only on edges where `enable` is high, so a low `enable` pauses the run with no loss.
- R9: Operands and quadrant are captured on the start edge. Changes on `xIn` and `yIn` after that edge do not affect the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for every register |
| rst | input | 1 | Synchronous reset, active high, clears all registers |
| enable | input | 1 | Advances the computation on each edge where it is high |
| start | input | 1 | One-cycle load strobe, qualified by `enable` |
| xIn | input | 32 | Signed x operand, 16Q16 |
| yIn | input | 32 | Signed y operand, 16Q16 |
| modOut | output | 32 | Magnitude, 16Q16 |
| angleOut | output | 33 | Signed angle in degrees, 9Q24 |

## Verification
The two results are due together, 34 enabled edges after the start edge: one load edge, 32 iteration edges and one correction edge. The bench counts exactly these edges, with edges taken while `enable` is low left out of the count, and reads both outputs at the following falling edge. For the pause case it also samples the outputs before and after a stretch with `enable` low, and checks that they did not move. The reset checks sample at a falling edge after a reset edge, because the reset takes effect one edge after it is raised.

// File: rtl/qpolar_pkg.sv
package qpolar_pkg;

  typedef struct packed {
    logic latchQuad;
    logic updateOut;
  } strobe_t;

  typedef struct packed {
    logic xNeg;
    logic yNeg;
  } quad_t;

  // arctangent of 2^-i in degrees; small angles use the linear term
  function automatic real atanDeg(input int i);
    case (i)
      0:  return 45.0;
      1:  return 26.565051177077990;
      2:  return 14.036243467926479;
      3:  return 7.125016348901798;
      4:  return 3.576334374997351;
      5:  return 1.789910608246069;
      6:  return 0.895173710211074;
      7:  return 0.447614170860553;
      8:  return 0.223810500368538;
      9:  return 0.111905677066207;
      10: return 0.055952891893804;
      11: return 0.027976452617004;
      default: return 57.29577951308232 / (2.0 ** i);
    endcase
  endfunction

  function automatic longint atanFixed(input int i, input int frac);
    return longint'(atanDeg(i) * (2.0 ** frac));
  endfunction

  // inverse of the accumulated CORDIC gain, as a fixed-point constant
  function automatic longint gainFixed(input int iters, input int frac);
    real k;
    k = 1.0;
    for (int i = 0; i < iters; i++) begin
      k = k / $sqrt(1.0 + (2.0 ** (-2 * i)));
    end
    return longint'(k * (2.0 ** frac));
  endfunction

endpackage

// File: rtl/cordic_vec_core.sv
module cordic_vec_core
  import qpolar_pkg::*;
#(
  parameter int W     = 32,
  parameter int AFRAC = 24,
  parameter int ITERS = 32,
  parameter int GUARD = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 enable,
  input  logic                 start,
  input  logic signed [W-1:0]  xIn,
  input  logic signed [W-1:0]  yIn,
  output logic signed [W-1:0]  modOut,
  output logic signed [7+AFRAC:0] angleOut
);
  localparam int IW    = W + GUARD;
  localparam int AW    = 8 + AFRAC;
  localparam int CW    = $clog2(ITERS + 1);
  localparam int IDXW  = $clog2(ITERS);
  localparam int KW    = 32;
  localparam int KFRAC = KW - 1;
  localparam logic signed [KW-1:0] GAIN_K = KW'(gainFixed(ITERS, KFRAC));

  logic signed [IW-1:0] xAcc, yAcc, xNext, yNext, xShift, yShift;
  logic signed [AW-1:0] zAcc, zNext, step;
  logic [CW-1:0]        iterCnt;
  logic                 active;
  logic signed [AW-1:0] atanRom [ITERS];
  logic signed [IW+KW-1:0] prod;

  for (genvar g = 0; g < ITERS; g++) begin : gRom
    assign atanRom[g] = AW'(atanFixed(g, AFRAC));
  end

  assign active = iterCnt < CW'(ITERS);

  always_comb begin
    xShift = xAcc >>> iterCnt;
    yShift = yAcc >>> iterCnt;
    step   = atanRom[iterCnt[IDXW-1:0]];
    if (yAcc[IW-1]) begin
      xNext = xAcc - yShift;
      yNext = yAcc + xShift;
      zNext = zAcc - step;
    end else begin
      xNext = xAcc + yShift;
      yNext = yAcc - xShift;
      zNext = zAcc + step;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xAcc    <= '0;
      yAcc    <= '0;
      zAcc    <= '0;
      iterCnt <= '0;
    end else if (enable) begin
      if (start) begin
        xAcc    <= {{GUARD{xIn[W-1]}}, xIn};
        yAcc    <= {{GUARD{yIn[W-1]}}, yIn};
        zAcc    <= '0;
        iterCnt <= '0;
      end else if (active) begin
        xAcc    <= xNext;
        yAcc    <= yNext;
        zAcc    <= zNext;
        iterCnt <= iterCnt + CW'(1);
      end
    end
  end

  assign prod     = xAcc * GAIN_K;
  assign modOut   = W'(prod >>> KFRAC);
  assign angleOut = zAcc;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    iterCnt <= CW'(ITERS)); // R8

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    enable && start |=> iterCnt == '0 && zAcc == '0); // R9

  AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !enable |=> $stable(iterCnt) && $stable(zAcc)); // R8

endmodule

// File: rtl/quad_polar_ctrl.sv
module quad_polar_ctrl
  import qpolar_pkg::*;
(
  input  logic    enable,
  input  logic    start,
  output strobe_t stb
);
  always_comb begin
    stb.latchQuad = enable & start;
    stb.updateOut = enable;
  end
endmodule

// File: rtl/quad_polar_dp.sv
module quad_polar_dp
  import qpolar_pkg::*;
#(
  parameter int W     = 32,
  parameter int AFRAC = 24
) (
  input  logic                   clk,
  input  logic                   rst,
  input  strobe_t                stb,
  input  logic signed [W-1:0]    xIn,
  input  logic signed [W-1:0]    yIn,
  input  logic signed [W-1:0]    coreMod,
  input  logic signed [7+AFRAC:0] coreAngle,
  output logic signed [W-1:0]    coreX,
  output logic signed [W-1:0]    coreY,
  output logic signed [W-1:0]    modOut,
  output logic signed [8+AFRAC:0] angleOut
);
  localparam int AW  = 8 + AFRAC;
  localparam int AOW = AW + 1;
  localparam logic signed [AOW-1:0] HALF_TURN = AOW'(64'(180) << AFRAC);

  quad_t quadNow, quadQ;
  logic signed [AOW-1:0] corr, angleNext;

  assign quadNow.xNeg = xIn[W-1];
  assign quadNow.yNeg = yIn[W-1];

  // mirror through the origin so the core always sees x >= 0
  assign coreX = quadNow.xNeg ? -xIn : xIn;
  assign coreY = quadNow.xNeg ? -yIn : yIn;

  always_comb begin
    if (!quadQ.xNeg)     corr = '0;
    else if (quadQ.yNeg) corr = -HALF_TURN;
    else                 corr = HALF_TURN;
    angleNext = {coreAngle[AW-1], coreAngle} + corr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      quadQ    <= '0;
      modOut   <= '0;
      angleOut <= '0;
    end else begin
      if (stb.latchQuad) quadQ <= quadNow;
      if (stb.updateOut) begin
        modOut   <= coreMod;
        angleOut <= angleNext;
      end
    end
  end

  AST_QUAD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !stb.latchQuad |=> $stable(quadQ)); // R9

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !stb.updateOut |=> $stable(angleOut) && $stable(modOut)); // R8

  AST_MOD_NONNEG: assert property (@(posedge clk) disable iff (rst)
    !modOut[W-1]); // R2

  AST_UPPER_LEFT_POS: assert property (@(posedge clk) disable iff (rst)
    stb.updateOut && quadQ.xNeg && !quadQ.yNeg |=> !angleOut[AOW-1]); // R4

  AST_LOWER_LEFT_NEG: assert property (@(posedge clk) disable iff (rst)
    stb.updateOut && quadQ.xNeg && quadQ.yNeg |=> angleOut[AOW-1]); // R5

endmodule

// File: rtl/quad_polar_conv.sv
module quad_polar_conv
  import qpolar_pkg::*;
#(
  parameter int W     = 32,
  parameter int AFRAC = 24,
  parameter int ITERS = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    enable,
  input  logic                    start,
  input  logic signed [W-1:0]     xIn,
  input  logic signed [W-1:0]     yIn,
  output logic signed [W-1:0]     modOut,
  output logic signed [8+AFRAC:0] angleOut
);
  strobe_t                 stb;
  logic signed [W-1:0]     coreX, coreY, coreMod;
  logic signed [7+AFRAC:0] coreAngle;

  quad_polar_ctrl ctrl_i (
    .enable (enable),
    .start  (start),
    .stb    (stb)
  );

  quad_polar_dp #(.W(W), .AFRAC(AFRAC)) dp_i (
    .clk       (clk),
    .rst       (rst),
    .stb       (stb),
    .xIn       (xIn),
    .yIn       (yIn),
    .coreMod   (coreMod),
    .coreAngle (coreAngle),
    .coreX     (coreX),
    .coreY     (coreY),
    .modOut    (modOut),
    .angleOut  (angleOut)
  );

  cordic_vec_core #(.W(W), .AFRAC(AFRAC), .ITERS(ITERS)) core_i (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .start    (start),
    .xIn      (coreX),
    .yIn      (coreY),
    .modOut   (coreMod),
    .angleOut (coreAngle)
  );
endmodule

// File: tb/quad_polar_conv_tb_top.sv
module quad_polar_conv_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_EDGES  = 34;
  localparam int NV         = 11;
  localparam real MOD_TOL   = 0.005;
  localparam real ANG_TOL   = 0.01;

  localparam int VX [NV] = '{ 3*65536,  4*65536, -3*65536,  -5*65536, 0,        0,
                              -6*65536, 1048608768, -98304, 6553600, -49152 };
  localparam int VY [NV] = '{ 4*65536, -3*65536,  4*65536, -12*65536, 7*65536, -7*65536,
                              0,        1048592384, 16384,  -32768,  -131072000 };

  logic clk = 1'b0;
  logic rst, enable, start;
  logic signed [31:0] xIn, yIn;
  logic signed [31:0] modOut;
  logic signed [32:0] angleOut;

  int testCount = 0;
  int failCount = 0;
  bit finished  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_polar_conv dut_i (
    .clk(clk), .rst(rst), .enable(enable), .start(start),
    .xIn(xIn), .yIn(yIn), .modOut(modOut), .angleOut(angleOut)
  );

  function automatic real modReal();
    return real'(modOut) / 65536.0;
  endfunction

  function automatic real angReal();
    return real'(angleOut) / 16777216.0;
  endfunction

  function automatic string angTag(input int xv, input int yv);
    if (xv > 0)       return "R3";
    else if (xv == 0) return "R7";
    else if (yv == 0) return "R6";
    else if (yv > 0)  return "R4";
    else              return "R5";
  endfunction

  task automatic checkNear(input string req, input real act, input real exp, input real tol);
    testCount++;
    if ((act - exp > tol) || (exp - act > tol)) begin
      failCount++;
      $display("FAIL %s: actual %f expected %f", req, act, exp);
    end
  endtask

  task automatic checkResult(input int xv, input int yv, input string req);
    real fx, fy;
    fx = real'(xv) / 65536.0;
    fy = real'(yv) / 65536.0;
    checkNear("R2", modReal(), $sqrt(fx*fx + fy*fy), MOD_TOL);
    checkNear(req, angReal(), $atan2(fy, fx) * 180.0 / 3.14159265358979, ANG_TOL);
  endtask

  // start edge plus 33 more enabled edges; optional pause and input swap
  task automatic runConv(input int xv, input int yv, input int pauseAt,
                         input bit doAlt, input int ax, input int ay);
    @(negedge clk);
    xIn = xv; yIn = yv; start = 1'b1; enable = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (doAlt) begin xIn = ax; yIn = ay; end
    for (int e = 1; e < RUN_EDGES; e++) begin
      if (e == pauseAt) begin
        real heldA, heldM;
        enable = 1'b0;
        heldA = angReal();
        heldM = modReal();
        repeat (6) @(negedge clk);
        checkNear("R8", angReal(), heldA, 0.0);
        checkNear("R8", modReal(), heldM, 0.0);
        enable = 1'b1;
      end
      @(negedge clk);
    end
    enable = 1'b0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  endtask

  initial begin
    rst = 1'b1; enable = 1'b0; start = 1'b0; xIn = '0; yIn = '0;
    repeat (3) @(negedge clk);
    // R1: outputs cleared by reset
    checkNear("R1", modReal(), 0.0, 0.0);
    checkNear("R1", angReal(), 0.0, 0.0);
    rst = 1'b0;

    // table walk covering every quadrant, axes and the range limit
    for (int i = 0; i < NV; i++) begin
      runConv(VX[i], VY[i], -1, 1'b0, 0, 0);
      checkResult(VX[i], VY[i], angTag(VX[i], VY[i]));
    end

    // R6: negative real axis must read +180, not -180
    runConv(-2*65536, 0, -1, 1'b0, 0, 0);
    checkNear("R6", angReal(), 180.0, ANG_TOL);

    // R8: idle cycles after completion leave results untouched
    begin
      real a0;
      a0 = angReal();
      repeat (8) @(negedge clk);
      checkNear("R8", angReal(), a0, 0.0);
    end

    // R8: pause mid-run, result still correct
    runConv(-7*65536, -2*65536, 12, 1'b0, 0, 0);
    checkResult(-7*65536, -2*65536, "R8");

    // R9: operands changed after the start edge to another quadrant
    runConv(-5*65536, 3*65536, -1, 1'b1, 9*65536, -4*65536);
    checkResult(-5*65536, 3*65536, "R9");

    // R1: reset in the middle of a run clears both outputs
    @(negedge clk);
    xIn = -4*65536; yIn = -4*65536; start = 1'b1; enable = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    checkNear("R1", modReal(), 0.0, 0.0);
    checkNear("R1", angReal(), 0.0, 0.0);
    rst = 1'b0; enable = 1'b0;

    finished = 1'b1;
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testCount++;
      failCount++;
      $display("FAIL R8: watchdog actual 200000 cycles expected completion earlier");
      summary();
    end
  end
endmodule